// File: doc/BRIEF.md
# Calibrated Per-Bank Peak Temperature Reducer

This block takes the raw readings of the sensing points that belong to one thermal bank, turns each into a linear temperature in milli-degrees with a signed gain and bias, and reports the hottest of them. A one-cycle start pulse captures the readings, the number of active points and the two calibration words. The block then walks the active points one per clock through a single multiply-add and a running maximum. When it is finished it raises a one-cycle done strobe, and the new result appears on the output in the same cycle.

Raw words may carry status or stale bits above the conversion code. Only the 12-bit code takes part in the conversion. Some readings convert to an implausibly hot value, as a sensor's first read often does. Any such reading counts as zero, so it cannot dominate the maximum.

Top module: `bank_peak_temp`

## Requirements
- R1: While reset is held and after it, before any start, temp_o is 0 and done_o is 0.
- R2: Only bits [11:0] of each 32-bit raw word enter the conversion. Point k occupies raw_words_i[32k+31:32k], and its upper 20 bits have no effect on temp_o.
- R3: Each point converts to offset_i + slope_i * code in 32-bit signed arithmetic, where code is the zero-extended 12-bit value. With slope -123 and offset 465124, code 3000 gives 96124 and code 4095 gives -38561.
- R4: A converted value greater than 200000 is replaced by 0 before the comparison. A value of exactly 200000 is kept.
- R5: The result is the maximum over points 0..N-1, where N is point_cnt_i. Points at index N and above have no effect. The running maximum starts at the most negative 32-bit value, so a bank of all-negative readings reports its true maximum.
- R6: Values of point_cnt_i from 5 to 7 act as 4.
- R7: With point_cnt_i = 0, temp_o becomes 32'h80000000 and done_o still pulses one cycle after the start edge.
- R8: done_o is high for exactly one cycle, max(N,1) rising edges after the edge that samples start_i. temp_o changes only in that cycle and holds until the next done.
- R9: Inputs are captured at the accepted start. Later changes to the data inputs, and start pulses that arrive while a bank is being processed, have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | One-cycle request to capture inputs and begin a bank |
| raw_words_i | input | 128 | Four raw sensing-point words, point 0 in the low 32 bits |
| point_cnt_i | input | 3 | Number of active points N |
| slope_i | input | 32 | Signed calibration gain |
| offset_i | input | 32 | Signed calibration bias in milli-degrees |
| temp_o | output | 32 | Signed bank maximum in milli-degrees |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The result and the done strobe are due max(N,1) rising edges after the edge that samples the start pulse: one edge captures the inputs and one edge is spent per active point. For every run the bench counts falling edges from the start edge. It checks that done stays low at each earlier sample and that done and temp_o are correct exactly at the due sample. One sample later it checks that done has fallen and the value has held. Each run scrambles the data inputs right after the start edge, so a result that depended on live inputs rather than the captured ones would show up.

// File: rtl/bank_peak_pkg.sv
package bank_peak_pkg;

  // Per-cycle control from the point sequencer to the max tracker.
  typedef struct packed {
    logic clear;  // start accepted: reset the running maximum
    logic take;   // current point is active and joins the maximum
    logic last;   // final step of the bank: publish the result
  } step_t;

endpackage

// File: rtl/bank_peak_seq.sv
module bank_peak_seq
  import bank_peak_pkg::*;
#(
  parameter int MAX_PTS = 4,
  parameter int CNT_W   = $clog2(MAX_PTS + 1),
  parameter int IDX_W   = $clog2(MAX_PTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output step_t            step_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);

  logic             busy_q, busy_d;
  logic             has_q, has_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] n_eff;
  logic             accept, at_last;

  always_comb begin
    n_eff   = (count_i > CNT_W'(MAX_PTS)) ? CNT_W'(MAX_PTS) : count_i;
    accept  = start_i && !busy_q;
    at_last = busy_q && (idx_q == last_q);

    busy_d = busy_q;
    idx_d  = idx_q;
    last_d = last_q;
    has_d  = has_q;
    if (accept) begin
      busy_d = 1'b1;
      idx_d  = '0;
      has_d  = (n_eff != '0);
      last_d = (n_eff == '0) ? '0 : IDX_W'(n_eff - CNT_W'(1));
    end else if (busy_q) begin
      busy_d = !at_last;
      idx_d  = idx_q + IDX_W'(1);
    end
    done_d = at_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      has_q  <= 1'b0;
      idx_q  <= '0;
      last_q <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      if (accept || busy_q) idx_q <= idx_d;
      if (accept) begin
        has_q  <= has_d;
        last_q <= last_d;
      end
    end
  end

  assign step_o.clear = accept;
  assign step_o.take  = busy_q && has_q;
  assign step_o.last  = at_last;
  assign idx_o        = idx_q;
  assign done_o       = done_q;

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R8
  done_ends_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> done_q);

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> $stable(last_q));

endmodule

// File: rtl/bank_peak_calib.sv
module bank_peak_calib #(
  parameter int CODE_W = 12,
  parameter int TEMP_W = 32,
  parameter int CEIL   = 200000
) (
  input  logic [CODE_W-1:0]        code_i,
  input  logic signed [TEMP_W-1:0] slope_i,
  input  logic signed [TEMP_W-1:0] offset_i,
  output logic signed [TEMP_W-1:0] temp_o
);

  localparam logic signed [TEMP_W-1:0] CEIL_S = TEMP_W'(CEIL);

  logic signed [TEMP_W-1:0] code_s;
  logic signed [TEMP_W-1:0] lin;

  always_comb begin
    code_s = $signed({{(TEMP_W - CODE_W){1'b0}}, code_i});
    lin    = offset_i + slope_i * code_s;
    temp_o = (lin > CEIL_S) ? '0 : lin;
  end

endmodule

// File: rtl/bank_peak_max.sv
module bank_peak_max
  import bank_peak_pkg::*;
#(
  parameter int TEMP_W = 32,
  parameter int CEIL   = 200000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  step_t                    step_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  output logic signed [TEMP_W-1:0] result_o
);

  localparam logic signed [TEMP_W-1:0] MIN_T  = {1'b1, {(TEMP_W - 1){1'b0}}};
  localparam logic signed [TEMP_W-1:0] CEIL_S = TEMP_W'(CEIL);

  logic signed [TEMP_W-1:0] run_q, run_d;
  logic signed [TEMP_W-1:0] res_q, res_d;
  logic signed [TEMP_W-1:0] cand;

  always_comb begin
    cand  = (step_i.take && (temp_i > run_q)) ? temp_i : run_q;
    run_d = step_i.clear ? MIN_T : cand;
    res_d = cand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= MIN_T;
      res_q <= '0;
    end else begin
      if (step_i.clear || step_i.take) run_q <= run_d;
      if (step_i.last) res_q <= res_d;
    end
  end

  assign result_o = res_q;

  // R4
  run_max_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CEIL_S);

endmodule

// File: rtl/bank_peak_temp.sv
module bank_peak_temp
  import bank_peak_pkg::*;
#(
  parameter int MAX_PTS = 4,
  parameter int RAW_W   = 32,
  parameter int CODE_W  = 12,
  parameter int TEMP_W  = 32,
  parameter int CEIL    = 200000,
  localparam int CNT_W  = $clog2(MAX_PTS + 1),
  localparam int IDX_W  = $clog2(MAX_PTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [MAX_PTS*RAW_W-1:0]   raw_words_i,
  input  logic [CNT_W-1:0]           point_cnt_i,
  input  logic signed [TEMP_W-1:0]   slope_i,
  input  logic signed [TEMP_W-1:0]   offset_i,
  output logic signed [TEMP_W-1:0]   temp_o,
  output logic                       done_o
);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  step_t                    step;
  logic [IDX_W-1:0]         idx;
  logic [CODE_W-1:0]        code_q [MAX_PTS];
  logic signed [TEMP_W-1:0] slope_q, offset_q;
  logic signed [TEMP_W-1:0] conv;
  logic [CODE_W-1:0]        sel_code;
  logic [MAX_PTS*(RAW_W-CODE_W)-1:0] unused_hi_bits;

  bank_peak_seq #(
    .MAX_PTS (MAX_PTS),
    .CNT_W   (CNT_W),
    .IDX_W   (IDX_W)
  ) seq_i (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .start_i (start_i),
    .count_i (point_cnt_i),
    .step_o  (step),
    .idx_o   (idx),
    .done_o  (done_o)
  );

  // Capture only the conversion code of each point.
  for (genvar k = 0; k < MAX_PTS; k++) begin : g_pt
    always_ff @(posedge clk or negedge rst_n_int) begin
      if (!rst_n_int)      code_q[k] <= '0;
      else if (step.clear) code_q[k] <= raw_words_i[k*RAW_W +: CODE_W];
    end
    assign unused_hi_bits[k*(RAW_W-CODE_W) +: (RAW_W-CODE_W)] =
      raw_words_i[k*RAW_W+CODE_W +: (RAW_W-CODE_W)];
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      slope_q  <= '0;
      offset_q <= '0;
    end else if (step.clear) begin
      slope_q  <= slope_i;
      offset_q <= offset_i;
    end
  end

  assign sel_code = code_q[idx];

  bank_peak_calib #(
    .CODE_W   (CODE_W),
    .TEMP_W   (TEMP_W),
    .CEIL     (CEIL)
  ) calib_i (
    .code_i   (sel_code),
    .slope_i  (slope_q),
    .offset_i (offset_q),
    .temp_o   (conv)
  );

  bank_peak_max #(
    .TEMP_W   (TEMP_W),
    .CEIL     (CEIL)
  ) max_i (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .step_i   (step),
    .temp_i   (conv),
    .result_o (temp_o)
  );

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    !done_o |-> $stable(temp_o));

endmodule

// File: tb/bank_peak_temp_tb_top.sv
`timescale 1ns/1ps
module bank_peak_temp_tb_top;

  localparam time CYC = 20ns;

  typedef struct packed {
    logic [127:0]       raw;
    logic [2:0]         n;
    logic signed [31:0] slope;
    logic signed [31:0] offset;
    logic signed [31:0] expv;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    // R3 R4 R5: mixed codes, the last point wins just below the ceiling
    '{{32'h0000086C, 32'h00000DAC, 32'h00000FFF, 32'h00000BB8}, 3'd4, -32'sd123, 32'sd465124, 32'sd199936},
    // R5: two points, hotter points 2 and 3 ignored
    '{{32'h00000BB8, 32'h00000BB8, 32'h00000DAC, 32'h00000FFF}, 3'd2, -32'sd123, 32'sd465124, 32'sd34624},
    // R5: single point
    '{{32'h00000000, 32'h00000000, 32'h00000BB8, 32'h00000FFF}, 3'd1, -32'sd123, 32'sd465124, -32'sd38561},
    // R4: implausible first reading becomes 0
    '{{32'h00000BB8, 32'h00000FFF, 32'h00000FFF, 32'h00000000}, 3'd3, -32'sd123, 32'sd465124, 32'sd0},
    // R4: exactly the ceiling kept, one above dropped
    '{{32'h00000005, 32'h0000000A, 32'h000007D1, 32'h000007D0}, 3'd4, 32'sd100, 32'sd0, 32'sd200000},
    // R2: upper raw bits ignored
    '{{32'h00000000, 32'h12340FFF, 32'hFFFFF000, 32'hABCD0BB8}, 3'd3, -32'sd123, 32'sd465124, 32'sd96124},
    // R5: all readings negative
    '{{32'h00000000, 32'h00000000, 32'h00000002, 32'h00000001}, 3'd2, -32'sd1000, -32'sd5000, -32'sd6000},
    // R3: maximum found at the last point
    '{{32'h00000BB8, 32'h00000FFF, 32'h00000FFF, 32'h00000FFF}, 3'd4, -32'sd123, 32'sd465124, 32'sd96124}
  };

  logic               clk;
  logic               rst_n;
  logic               start_i;
  logic [127:0]       raw_words_i;
  logic [2:0]         point_cnt_i;
  logic signed [31:0] slope_i;
  logic signed [31:0] offset_i;
  logic signed [31:0] temp_o;
  logic               done_o;

  int checks = 0;
  int errors = 0;

  bank_peak_temp dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .raw_words_i (raw_words_i),
    .point_cnt_i (point_cnt_i),
    .slope_i     (slope_i),
    .offset_i    (offset_i),
    .temp_o      (temp_o),
    .done_o      (done_o)
  );

  initial clk = 1'b0;
  always #(CYC/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic run(input vec_t v, input string req, input bit restart);
    int lat;
    lat = (v.n == 3'd0) ? 1 : ((v.n > 3'd4) ? 4 : int'(v.n));
    @(negedge clk);
    raw_words_i = v.raw;
    point_cnt_i = v.n;
    slope_i     = v.slope;
    offset_i    = v.offset;
    start_i     = 1'b1;
    @(negedge clk);
    // R9: scramble inputs once captured
    start_i     = restart;
    raw_words_i = ~v.raw;
    point_cnt_i = 3'd1;
    slope_i     = 32'sd7;
    offset_i    = 32'sd150000;
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      start_i = 1'b0;
      if (k < lat)
        chk(done_o == 1'b0, {req, " R8 early done"}, int'(done_o), 0);
    end
    chk(done_o == 1'b1, {req, " R8 done due"}, int'(done_o), 1);
    chk(temp_o == v.expv, {req, " result"}, temp_o, v.expv);
    @(negedge clk);
    chk(done_o == 1'b0, {req, " R8 done single"}, int'(done_o), 0);
    chk(temp_o == v.expv, {req, " R8 hold"}, temp_o, v.expv);
  endtask

  initial begin
    #(CYC * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    vec_t v;
    rst_n       = 1'b0;
    start_i     = 1'b0;
    raw_words_i = '0;
    point_cnt_i = '0;
    slope_i     = '0;
    offset_i    = '0;
    repeat (3) @(negedge clk);
    chk(temp_o == 32'sd0, "R1 reset temp", temp_o, 0);
    chk(done_o == 1'b0, "R1 reset done", int'(done_o), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(temp_o == 32'sd0, "R1 post-reset temp", temp_o, 0);
    chk(done_o == 1'b0, "R1 post-reset done", int'(done_o), 0);

    for (int i = 0; i < NV; i++) run(VECS[i], $sformatf("vec%0d R3 R5", i), 1'b0);

    // R7: empty bank
    v = VECS[0];
    v.n = 3'd0;
    v.expv = 32'sh80000000;
    run(v, "R7 empty bank", 1'b0);

    // R6: counts above four saturate
    v = VECS[0];
    v.n = 3'd7;
    run(v, "R6 count 7", 1'b0);
    v = VECS[7];
    v.n = 3'd5;
    run(v, "R6 count 5", 1'b0);

    // R9: a start during a run is ignored
    run(VECS[0], "R9 restart while busy", 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule